// File: doc/BRIEF.md
# Eight-Slot Vectored Interrupt Controller with Skip Polling

This controller sits beside a small 4-bit processor core and turns nine event pulses into interrupt requests. The pulses come from two external pins, five timers, an analog-to-digital converter and a serial port. Each pulse sets a sticky request flag. Nine flags feed eight priority slots. The lowest slot is shared by timer 4 and the serial port, and a select input chooses which of the two drives it.

Each slot has an enable bit. The eight bits live in two 4-bit enable registers, A and B. A set enable bit lets the slot interrupt. A clear enable bit keeps the slot silent, and software then polls the flag with a skip test. A skip test that finds its flag set reports a hit and consumes the flag.

A global enable flag gates all interrupts. The core sets it with an EI command and clears it with a DI command, and taking an interrupt also clears it. When an interrupt is taken, the controller raises a one-cycle take strobe with a 12-bit vector address in page 1.

Top module: `ivc_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `flags` is 0, `gie` is 0 and `take` is 0. Reset also clears both enable registers to 0.
- R2: A high `evt_pulse` bit sets the matching flag at the next clock edge, whatever the enable settings. The bit order is: 0 external 0, 1 external 1, 2 timer 1, 3 timer 2, 4 timer 3, 5 timer 5, 6 A/D, 7 timer 4, 8 serial. A set flag stays set until it is cleared by a take or by a skip hit.
- R3: `take` is high only when `gie` is 1 and at least one slot has both its flag and its enable bit at 1. `take` is combinational from the registered state and `slot_sel`. The same cycle then lasts at most one clock cycle.
- R4: Slots 0 to 7 have priority from highest to lowest in this order: external 0, external 1, timer 1, timer 2, timer 3, timer 5, A/D, and the timer 4 / serial slot. When `take` is high, `vector` is 0x080 + 2 × (winning slot), which is page 1 with a 7-bit page offset.
- R5: At the clock edge that ends a take cycle, only the winning source's flag is cleared, and `gie` goes to 0.
- R6: `cmd_ei` sets `gie` and `cmd_di` clears it. A take in the same cycle overrides `cmd_ei`. A flag that became pending while `gie` was 0 is taken once `gie` is 1, with no new event needed.
- R7: `en_wr_a` loads `en_wdata` into enable register A and `en_wr_b` loads it into register B. Bit n of A enables slot n (slots 0 to 3). Bit n of B enables slot 4+n (slots 4 to 7).
- R8: When `slot_sel` is 0, slot 7 takes the timer 4 flag (bit 7). When `slot_sel` is 1, slot 7 takes the serial flag (bit 8). Both sources share enable bit B[3].
- R9: `skip_src` selects a flag by its index from R2. When `skip_req` is 1, `skip_hit` is high in the same cycle if that flag is 1 and its slot's enable bit is 0. The flag then clears at the next edge.
- R10: A skip test whose flag is 0 or whose slot enable bit is 1 gives `skip_hit` = 0 and leaves `flags` unchanged.
- R11: When an event pulse arrives in the same cycle as a clear of the same flag, whether from a take or from a skip hit, the event wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 9 | One-cycle event pulses, one bit per source |
| en_wr_a | input | 1 | Load enable register A (slots 0-3) |
| en_wr_b | input | 1 | Load enable register B (slots 4-7) |
| en_wdata | input | 4 | Data for the enable register writes |
| slot_sel | input | 1 | Slot 7 source: 0 = timer 4, 1 = serial |
| cmd_ei | input | 1 | Set the global enable |
| cmd_di | input | 1 | Clear the global enable |
| skip_req | input | 1 | Skip-test request |
| skip_src | input | 4 | Flag index under test |
| skip_hit | output | 1 | The skip test succeeded |
| take | output | 1 | Interrupt taken this cycle |
| vector | output | 12 | Vector address of the taken interrupt |
| gie | output | 1 | Global enable flag |
| flags | output | 9 | Request flags |

## Verification
The assertions check the following on every cycle:
- an event always sets its flag;
- a flag never drops without a take or a skip hit;
- a take needs `gie` and a pending flag, and is always followed by `gie` at 0;
- vectors stay inside page 1 at even offsets;
- a skip hit needs a pending flag.

Only the bench scenarios can show the rest:
- the exact priority order;
- the enable-register bit mapping;
- the slot 7 selection between timer 4 and serial;
- that only the winning flag clears;
- that an event beats a same-cycle take or skip clear.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int NUM_SRC   = 9;
    localparam int NUM_SLOT  = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOT);
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int EN_W      = NUM_SLOT / 2;
    localparam int ADDR_W    = 12;
    localparam int SHARED    = NUM_SLOT - 1;

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT0 = 4'd0,
        SRC_EXT1 = 4'd1,
        SRC_TMR1 = 4'd2,
        SRC_TMR2 = 4'd3,
        SRC_TMR3 = 4'd4,
        SRC_TMR5 = 4'd5,
        SRC_ADC  = 4'd6,
        SRC_TMR4 = 4'd7,
        SRC_SER  = 4'd8
    } src_e;

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
    } grant_t;

    // Slot that owns the enable bit of a given flag index.
    function automatic int slot_of_src(input int src);
        return (src < NUM_SLOT) ? src : SHARED;
    endfunction

    // Vector address: page number above the page offset, two words per slot.
    function automatic logic [ADDR_W-1:0] slot_vector(
        input logic [SLOT_W-1:0] slot,
        input int                page_num,
        input int                page_bits
    );
        logic [ADDR_W-1:0] base;
        base = ADDR_W'(page_num) << page_bits;
        return base | ADDR_W'({slot, 1'b0});
    endfunction

endpackage

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
    parameter int N = ivc_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_o[i] <= 1'b0;
            else if (set_i[i])
                flag_o[i] <= 1'b1;
            else if (clr_i[i])
                flag_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/ivc_slot_mux.sv
module ivc_slot_mux
    import ivc_pkg::*;
(
    input  logic [NUM_SRC-1:0]  flag_i,
    input  logic                sel_i,
    output logic [NUM_SLOT-1:0] req_o
);
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        if (s == SHARED) begin : g_shared
            assign req_o[s] = sel_i ? flag_i[SRC_SER] : flag_i[SRC_TMR4];
        end else begin : g_direct
            assign req_o[s] = flag_i[s];
        end
    end
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc
    import ivc_pkg::*;
(
    input  logic [NUM_SLOT-1:0] req_i,
    output grant_t              grant_o
);
    always_comb begin
        grant_o = '0;
        for (int i = NUM_SLOT - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o.valid = 1'b1;
                grant_o.slot  = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/ivc_skip_unit.sv
module ivc_skip_unit
    import ivc_pkg::*;
(
    input  logic                skip_req_i,
    input  logic [SRC_W-1:0]    skip_src_i,
    input  logic [NUM_SRC-1:0]  flag_i,
    input  logic [NUM_SLOT-1:0] slot_en_i,
    output logic [NUM_SRC-1:0]  clr_o,
    output logic                hit_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int EN_IDX = slot_of_src(i);
        assign clr_o[i] = skip_req_i && (skip_src_i == SRC_W'(i))
                        && flag_i[i] && !slot_en_i[EN_IDX];
    end
    assign hit_o = |clr_o;
endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int PAGE_NUM  = 1,
    parameter int PAGE_BITS = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  evt_pulse,
    input  logic                en_wr_a,
    input  logic                en_wr_b,
    input  logic [EN_W-1:0]     en_wdata,
    input  logic                slot_sel,
    input  logic                cmd_ei,
    input  logic                cmd_di,
    input  logic                skip_req,
    input  logic [SRC_W-1:0]    skip_src,
    output logic                skip_hit,
    output logic                take,
    output logic [ADDR_W-1:0]   vector,
    output logic                gie,
    output logic [NUM_SRC-1:0]  flags
);
    logic [EN_W-1:0]     en_a_q, en_b_q;
    logic [NUM_SLOT-1:0] slot_en, slot_req, slot_arm;
    logic [NUM_SRC-1:0]  take_clr, skip_clr, flag_clr;
    grant_t              grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_a_q <= '0;
            en_b_q <= '0;
        end else begin
            if (en_wr_a) en_a_q <= en_wdata;
            if (en_wr_b) en_b_q <= en_wdata;
        end
    end
    assign slot_en = {en_b_q, en_a_q};

    always_ff @(posedge clk) begin
        if (rst)         gie <= 1'b0;
        else if (take)   gie <= 1'b0;
        else if (cmd_ei) gie <= 1'b1;
        else if (cmd_di) gie <= 1'b0;
    end

    ivc_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_pulse),
        .clr_i  (flag_clr),
        .flag_o (flags)
    );

    ivc_slot_mux u_mux (
        .flag_i (flags),
        .sel_i  (slot_sel),
        .req_o  (slot_req)
    );

    assign slot_arm = slot_req & slot_en;

    ivc_prio_enc u_prio (
        .req_i   (slot_arm),
        .grant_o (grant)
    );

    assign take   = gie && grant.valid;
    assign vector = slot_vector(grant.slot, PAGE_NUM, PAGE_BITS);

    // Map the winning slot back to the flag it consumes.
    always_comb begin
        take_clr = '0;
        if (take) begin
            for (int s = 0; s < SHARED; s++)
                if (grant.slot == SLOT_W'(s)) take_clr[s] = 1'b1;
            if (grant.slot == SLOT_W'(SHARED)) begin
                if (slot_sel) take_clr[SRC_SER]  = 1'b1;
                else          take_clr[SRC_TMR4] = 1'b1;
            end
        end
    end

    ivc_skip_unit u_skip (
        .skip_req_i (skip_req),
        .skip_src_i (skip_src),
        .flag_i     (flags),
        .slot_en_i  (slot_en),
        .clr_o      (skip_clr),
        .hit_o      (skip_hit)
    );

    assign flag_clr = take_clr | skip_clr;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
#(
    parameter int PAGE_NUM  = 1,
    parameter int PAGE_BITS = 7
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic               skip_req,
    input logic               skip_hit,
    input logic               take,
    input logic [ADDR_W-1:0]  vector,
    input logic               gie,
    input logic [NUM_SRC-1:0] flags
);
    a_r2_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((flags & $past(evt_pulse)) == $past(evt_pulse)));

    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (!take && !skip_hit) |=> ((flags & $past(flags)) == $past(flags)));

    a_r3_take_needs_gie: assert property (@(posedge clk) disable iff (rst)
        take |-> gie);

    a_r3_take_needs_flag: assert property (@(posedge clk) disable iff (rst)
        take |-> (flags != '0));

    a_r5_take_drops_gie: assert property (@(posedge clk) disable iff (rst)
        take |=> (!gie && !take));

    a_r4_vector_in_page: assert property (@(posedge clk) disable iff (rst)
        take |-> ((int'(vector >> PAGE_BITS) == PAGE_NUM) && !vector[0]));

    a_r9_skip_needs_flag: assert property (@(posedge clk) disable iff (rst)
        skip_hit |-> (skip_req && (flags != '0)));
endmodule

bind ivc_top ivc_checker #(.PAGE_NUM(PAGE_NUM), .PAGE_BITS(PAGE_BITS)) u_chk (.*);

// File: tb/tb_ivc_top.sv
module tb_ivc_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  evt_pulse;
    logic        en_wr_a, en_wr_b;
    logic [3:0]  en_wdata;
    logic        slot_sel, cmd_ei, cmd_di, skip_req;
    logic [3:0]  skip_src;
    logic        skip_hit, take, gie;
    logic [11:0] vector;
    logic [8:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ivc_top dut (.*);

    typedef struct packed {
        logic [8:0]  evt;
        logic        wa;
        logic        wb;
        logic [3:0]  wd;
        logic        ei;
        logic        di;
        logic [8:0]  eflags;
        logic        egie;
        logic        etake;
        logic [11:0] evec;
    } row_t;

    localparam int NROWS = 19;
    localparam row_t TABLE [NROWS] = '{
        '{9'h004, 0, 0, 4'h0, 0, 0, 9'h004, 0, 0, 12'h000}, // R2 timer1 set
        '{9'h100, 0, 0, 4'h0, 0, 0, 9'h104, 0, 0, 12'h000}, // R2 serial set
        '{9'h000, 1, 0, 4'hF, 0, 0, 9'h104, 0, 0, 12'h000}, // R7 A=F, gie 0
        '{9'h000, 0, 0, 4'h0, 1, 0, 9'h104, 1, 1, 12'h084}, // R6 late EI
        '{9'h000, 0, 0, 4'h0, 0, 0, 9'h100, 0, 0, 12'h000}, // R5 clear
        '{9'h000, 0, 1, 4'h8, 0, 0, 9'h100, 0, 0, 12'h000}, // R8 sel 0
        '{9'h000, 0, 0, 4'h0, 1, 0, 9'h100, 1, 0, 12'h000}, // R8 serial hidden
        '{9'h081, 0, 0, 4'h0, 0, 0, 9'h181, 1, 1, 12'h080}, // R4 ext0 first
        '{9'h000, 0, 0, 4'h0, 0, 0, 9'h180, 0, 0, 12'h000}, // R5
        '{9'h000, 0, 0, 4'h0, 1, 0, 9'h180, 1, 1, 12'h08E}, // R4 timer4 slot
        '{9'h000, 0, 0, 4'h0, 0, 0, 9'h100, 0, 0, 12'h000}, // R5
        '{9'h000, 0, 0, 4'h0, 1, 0, 9'h100, 1, 0, 12'h000}, // R6 EI
        '{9'h000, 0, 0, 4'h0, 0, 1, 9'h100, 0, 0, 12'h000}, // R6 DI
        '{9'h060, 0, 0, 4'h0, 0, 0, 9'h160, 0, 0, 12'h000}, // R2
        '{9'h000, 0, 1, 4'hF, 0, 0, 9'h160, 0, 0, 12'h000}, // R7 B=F
        '{9'h000, 0, 0, 4'h0, 1, 0, 9'h160, 1, 1, 12'h08A}, // R4 timer5
        '{9'h000, 0, 0, 4'h0, 0, 0, 9'h140, 0, 0, 12'h000}, // R5
        '{9'h000, 0, 0, 4'h0, 1, 0, 9'h140, 1, 1, 12'h08C}, // R4 A/D
        '{9'h000, 0, 0, 4'h0, 0, 0, 9'h100, 0, 0, 12'h000}  // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        evt_pulse = '0; en_wr_a = 0; en_wr_b = 0; en_wdata = '0;
        cmd_ei = 0; cmd_di = 0; skip_req = 0; skip_src = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        slot_sel = 0;
        rst = 1;
        step(); step();
        rst = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 flags", 32'(flags), 0);
        check("R1 gie", 32'(gie), 0);
        check("R1 take", 32'(take), 0);

        // Table walk
        for (int i = 0; i < NROWS; i++) begin
            evt_pulse = TABLE[i].evt; en_wr_a = TABLE[i].wa; en_wr_b = TABLE[i].wb;
            en_wdata = TABLE[i].wd; cmd_ei = TABLE[i].ei; cmd_di = TABLE[i].di;
            step();
            idle();
            check($sformatf("R2/R5 row%0d flags", i), 32'(flags), 32'(TABLE[i].eflags));
            check($sformatf("R6 row%0d gie", i), 32'(gie), 32'(TABLE[i].egie));
            check($sformatf("R3 row%0d take", i), 32'(take), 32'(TABLE[i].etake));
            if (TABLE[i].etake)
                check($sformatf("R4 row%0d vector", i), 32'(vector), 32'(TABLE[i].evec));
        end

        // R9 valid skip on disabled source
        do_reset();
        evt_pulse = 9'h002; step(); idle();
        skip_req = 1; skip_src = 4'd1;
        #1 check("R9 skip hit", 32'(skip_hit), 1);
        step(); idle();
        check("R9 flag consumed", 32'(flags), 0);

        // R10 skip on clear flag
        skip_req = 1; skip_src = 4'd1;
        #1 check("R10 no hit when clear", 32'(skip_hit), 0);
        step(); idle();
        check("R10 flags unchanged", 32'(flags), 0);

        // R10 skip on enabled source
        en_wr_a = 1; en_wdata = 4'h2; step(); idle();
        evt_pulse = 9'h002; step(); idle();
        skip_req = 1; skip_src = 4'd1;
        #1 check("R10 no hit when enabled", 32'(skip_hit), 0);
        step(); idle();
        check("R10 flag kept", 32'(flags), 32'h002);

        // R11 event beats skip clear
        evt_pulse = 9'h010; step(); idle();
        evt_pulse = 9'h010; skip_req = 1; skip_src = 4'd4;
        #1 check("R11 skip hit with event", 32'(skip_hit), 1);
        step(); idle();
        check("R11 event wins over skip", 32'(flags), 32'h012);

        // R11 event beats take clear
        cmd_ei = 1; step(); idle();
        check("R3 take ext1", 32'(take), 1);
        check("R4 vector ext1", 32'(vector), 32'h082);
        evt_pulse = 9'h002; step(); idle();
        check("R11 event wins over take", 32'(flags), 32'h012);
        check("R5 gie dropped", 32'(gie), 0);

        // R8 serial through shared slot, R5 only winner cleared
        do_reset();
        en_wr_b = 1; en_wdata = 4'h8; step(); idle();
        evt_pulse = 9'h180; step(); idle();
        slot_sel = 1; cmd_ei = 1; step(); idle();
        check("R8 serial take", 32'(take), 1);
        check("R8 serial vector", 32'(vector), 32'h08E);
        step();
        check("R5 only serial cleared", 32'(flags), 32'h080);

        // R6 take overrides EI in the same cycle
        slot_sel = 0; cmd_ei = 1; step(); idle();
        check("R8 timer4 take", 32'(take), 1);
        cmd_ei = 1; step(); idle();
        check("R6 take beats EI", 32'(gie), 0);
        check("R5 timer4 cleared", 32'(flags), 0);

        // R3 enable bits gate take even with gie set
        do_reset();
        evt_pulse = 9'h001; cmd_ei = 1; step(); idle();
        check("R3 gie set", 32'(gie), 1);
        check("R3 masked no take", 32'(take), 0);
        // R7 enabling bit 0 of A releases it
        en_wr_a = 1; en_wdata = 4'h1; step(); idle();
        check("R7 A bit0 enables ext0", 32'(take), 1);
        check("R4 vector ext0", 32'(vector), 32'h080);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule